// File: doc/BRIEF.md
# Password Verification Engine

The engine decides whether a programming session may proceed by checking an unlock password against on-chip memory. It receives a count address and a compare-start address from the stage that runs the entry handshake, then reads memory through a synchronous read port. Each read returns its data on the cycle after the request.

It first scans the 32 bytes at the top of the address space. If every one of them reads FFH, the part counts as blank and the engine passes without touching any password byte. Otherwise it fetches the password length N from the count address. It then checks N bytes arriving from the UART receiver, one by one, against N consecutive memory bytes starting at the compare-start address.

A mismatch or a receive error ends in a silent halt. Nothing is echoed or transmitted in any case. Pass and halt are held until reset.

Top module: `pwd_verify`

## Requirements
- R1: While reset is asserted and after it is released, busy_o, pass_o, halt_o and mem_re_o are all 0.
- R2: A start_i pulse taken while idle (busy_o, pass_o and halt_o all 0) makes the engine issue blank-scan reads on the cycles that follow: first address FFE0H in the cycle right after start, then one address higher on each following cycle.
- R3: When all 32 bytes from FFE0H to FFFFH read FFH, pass_o rises after exactly 32 reads. No other address is read, and password bytes arriving on rx are ignored.
- R4: When offset k (0 to 31) is the first byte in the top region that is not FFH, the scan reads exactly offsets 0 through k. The next read is the count address.
- R5: The length N is the byte read at the count address. Expected byte i is read at (compare-start + i) modulo 2^16. Read data is taken from mem_rdata_i one cycle after mem_re_o.
- R6: When all N received bytes equal their expected bytes, in order, pass_o rises and halt_o stays 0.
- R7: A received byte that differs from its expected byte raises halt_o and no further memory reads are made. pass_o never rises, and later rx bytes change nothing.
- R8: A password byte flagged with rx_err_i raises halt_o on the next cycle.
- R9: On a part that is not blank, N = 0 gives pass_o with no read beyond the count address.
- R10: pass_o and halt_o are never both 1. Each holds until reset. start_i has no effect unless the engine is idle.
- R11: mem_re_o is 0 whenever busy_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a verification (taken only when idle) |
| cnt_addr_i | input | 16 | Address holding the password length |
| cmp_addr_i | input | 16 | Address of the first expected password byte |
| mem_re_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory read address |
| mem_rdata_i | input | 8 | Read data, valid the cycle after a request |
| rx_valid_i | input | 1 | Received byte strobe |
| rx_data_i | input | 8 | Received byte |
| rx_err_i | input | 1 | Receive error on the strobed byte |
| busy_o | output | 1 | Verification in progress |
| pass_o | output | 1 | Password accepted or blank part (held) |
| halt_o | output | 1 | Verification failed (held) |

## Verification
The assertions assume that start_i and rx_valid_i are driven to known values from reset onward. They also assume the memory answers every request on the next cycle, and that received bytes arrive at least three cycles apart, so that one prefetch and compare can finish before the next byte lands. The stimulus keeps to this in three ways. It pulses start only from idle, then waits for the scan and length fetch to finish. It sends each byte as a one-cycle strobe followed by four idle cycles. Its memory model answers every read on the following edge.

// File: rtl/pwd_pkg.sv
package pwd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SCAN, ST_LEN_RD, ST_LEN_WT, ST_CMP, ST_PASS, ST_HALT
  } pwd_st_e;
endpackage

// File: rtl/pwd_scan.sv
module pwd_scan #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8,
  parameter logic [AW-1:0] BASE = '1 - 31,
  parameter int unsigned LEN = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [DW-1:0] rdata_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          blank_o,
  output logic          used_o
);
  localparam int unsigned IW = (LEN > 1) ? $clog2(LEN) : 1;

  logic [IW:0]   iss_q;
  logic [IW-1:0] chk_idx_q;
  logic          chk_vld_q;
  logic          hit, all_ones;

  assign hit       = en_i && chk_vld_q;
  assign all_ones  = &rdata_i;
  assign used_o    = hit && !all_ones;
  assign blank_o   = hit && all_ones && (chk_idx_q == IW'(LEN - 1));
  // stop issuing as soon as a programmed byte is seen
  assign rd_req_o  = en_i && (iss_q < (IW+1)'(LEN)) && !used_o;
  assign rd_addr_o = BASE + AW'(iss_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iss_q     <= '0;
      chk_idx_q <= '0;
      chk_vld_q <= 1'b0;
    end else if (clr_i) begin
      iss_q     <= '0;
      chk_vld_q <= 1'b0;
    end else begin
      chk_vld_q <= rd_req_o;
      if (rd_req_o) begin
        chk_idx_q <= iss_q[IW-1:0];
        iss_q     <= iss_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwd_cmp.sv
module pwd_cmp #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic [AW-1:0] base_i,
  input  logic [DW-1:0] len_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          match_o,
  output logic          miss_o
);
  logic [DW-1:0] idx_q, exp_q, rx_q;
  logic          inflight_q, exp_vld_q, rx_pend_q;
  logic          ready;

  assign ready     = en_i && exp_vld_q && rx_pend_q;
  assign miss_o    = ready && (rx_q != exp_q);
  assign match_o   = ready && (rx_q == exp_q) && ((idx_q + 1'b1) == len_i);
  // prefetch the expected byte for the current index
  assign rd_req_o  = en_i && !exp_vld_q && !inflight_q;
  assign rd_addr_o = base_i + AW'(idx_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q      <= '0;
      exp_q      <= '0;
      rx_q       <= '0;
      inflight_q <= 1'b0;
      exp_vld_q  <= 1'b0;
      rx_pend_q  <= 1'b0;
    end else if (clr_i) begin
      idx_q      <= '0;
      inflight_q <= 1'b0;
      exp_vld_q  <= 1'b0;
      rx_pend_q  <= 1'b0;
    end else if (en_i) begin
      if (rd_req_o) inflight_q <= 1'b1;
      if (inflight_q) begin
        exp_q      <= rdata_i;
        exp_vld_q  <= 1'b1;
        inflight_q <= 1'b0;
      end
      if (ready && !miss_o) begin
        idx_q     <= idx_q + 1'b1;
        exp_vld_q <= 1'b0;
        rx_pend_q <= 1'b0;
      end
      if (rx_valid_i) begin
        rx_q      <= rx_data_i;
        rx_pend_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwd_verify.sv
module pwd_verify #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8,
  parameter int unsigned BLANK_LEN = 32,
  parameter logic [AW-1:0] BLANK_BASE = AW'((1 << AW) - BLANK_LEN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] cnt_addr_i,
  input  logic [AW-1:0] cmp_addr_i,
  output logic          mem_re_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          rx_err_i,
  output logic          busy_o,
  output logic          pass_o,
  output logic          halt_o
);
  import pwd_pkg::*;

  pwd_st_e       st_q, st_d;
  logic [AW-1:0] cnt_q, cmp_q;
  logic [DW-1:0] n_q;
  logic          accept, cmp_act;
  logic          scan_re, scan_blank, scan_used;
  logic [AW-1:0] scan_addr, cmp_addr;
  logic          cmp_re, cmp_match, cmp_miss;

  assign accept  = (st_q == ST_IDLE) && start_i;
  assign cmp_act = (st_q == ST_CMP);

  pwd_scan #(.AW(AW), .DW(DW), .BASE(BLANK_BASE), .LEN(BLANK_LEN)) u_scan (
    .clk_i, .rst_ni,
    .clr_i     (accept),
    .en_i      (st_q == ST_SCAN),
    .rdata_i   (mem_rdata_i),
    .rd_req_o  (scan_re),
    .rd_addr_o (scan_addr),
    .blank_o   (scan_blank),
    .used_o    (scan_used)
  );

  pwd_cmp #(.AW(AW), .DW(DW)) u_cmp (
    .clk_i, .rst_ni,
    .clr_i      (st_q == ST_LEN_WT),
    .en_i       (cmp_act),
    .base_i     (cmp_q),
    .len_i      (n_q),
    .rdata_i    (mem_rdata_i),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .rd_req_o   (cmp_re),
    .rd_addr_o  (cmp_addr),
    .match_o    (cmp_match),
    .miss_o     (cmp_miss)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (start_i) st_d = ST_SCAN;
      ST_SCAN:   if (scan_used) st_d = ST_LEN_RD;
                 else if (scan_blank) st_d = ST_PASS;
      ST_LEN_RD: st_d = ST_LEN_WT;
      ST_LEN_WT: st_d = (mem_rdata_i == '0) ? ST_PASS : ST_CMP;
      ST_CMP:    if (rx_valid_i && rx_err_i) st_d = ST_HALT;
                 else if (cmp_miss) st_d = ST_HALT;
                 else if (cmp_match) st_d = ST_PASS;
      default:   st_d = st_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      cmp_q <= '0;
      n_q   <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        cnt_q <= cnt_addr_i;
        cmp_q <= cmp_addr_i;
      end
      if (st_q == ST_LEN_WT) n_q <= mem_rdata_i;
    end
  end

  always_comb begin
    mem_re_o   = 1'b0;
    mem_addr_o = '0;
    unique case (st_q)
      ST_SCAN:   begin mem_re_o = scan_re; mem_addr_o = scan_addr; end
      ST_LEN_RD: begin mem_re_o = 1'b1;    mem_addr_o = cnt_q;     end
      ST_CMP:    begin mem_re_o = cmp_re;  mem_addr_o = cmp_addr;  end
      default:   ;
    endcase
  end

  assign busy_o = (st_q == ST_SCAN) || (st_q == ST_LEN_RD) ||
                  (st_q == ST_LEN_WT) || (st_q == ST_CMP);
  assign pass_o = (st_q == ST_PASS);
  assign halt_o = (st_q == ST_HALT);
endmodule

// File: rtl/pwd_verify_chk.sv
module pwd_verify_chk #(
  parameter int unsigned AW = 16,
  parameter logic [AW-1:0] BASE = '0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          pass_o,
  input logic          halt_o,
  input logic          mem_re_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          rx_valid_i,
  input logic          rx_err_i,
  input logic          cmp_act_i
);
  assert_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_o && halt_o));

  assert_pass_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |=> pass_o);

  assert_halt_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o && !pass_o);

  assert_scan_first_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !pass_o && !halt_o) |=> (mem_re_o && mem_addr_o == BASE));

  assert_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_re_o);

  assert_rx_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_act_i && rx_valid_i && rx_err_i) |=> halt_o);
endmodule

bind pwd_verify pwd_verify_chk #(.AW(AW), .BASE(BLANK_BASE)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .pass_o     (pass_o),
  .halt_o     (halt_o),
  .mem_re_o   (mem_re_o),
  .mem_addr_o (mem_addr_o),
  .rx_valid_i (rx_valid_i),
  .rx_err_i   (rx_err_i),
  .cmp_act_i  (cmp_act)
);

// File: tb/pwd_verify_test.sv
module pwd_verify_test;
  localparam logic [15:0] BASE = 16'hFFE0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] cnt_addr = '0, cmp_addr = '0;
  logic        mem_re;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic        rx_valid = 1'b0, rx_err = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        busy, pass, halt;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  logic [7:0] mem [int];
  logic [15:0] exp_addr_q [$];
  bit          exp_out_q [$];
  logic [7:0]  pw_buf [0:7];
  bit          done_prev = 1'b0;

  always #5 clk = ~clk;

  pwd_verify uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .cnt_addr_i(cnt_addr), .cmp_addr_i(cmp_addr),
    .mem_re_o(mem_re), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_err_i(rx_err),
    .busy_o(busy), .pass_o(pass), .halt_o(halt)
  );

  function automatic logic [7:0] rd(input logic [15:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return 8'hFF;
  endfunction

  always @(posedge clk) if (mem_re) mem_rdata <= rd(mem_addr);

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // monitor: read addresses and outcomes against the scoreboard queues
  always @(negedge clk) begin
    if (rst_n && mem_re) begin
      if (exp_addr_q.size() == 0)
        check(1'b0, cur_req, "unexpected read", int'(mem_addr), 0);
      else begin
        logic [15:0] e;
        e = exp_addr_q.pop_front();
        check(mem_addr == e, cur_req, "read address", int'(mem_addr), int'(e));
      end
    end
    if (rst_n && (pass || halt) && !done_prev) begin
      if (exp_out_q.size() == 0)
        check(1'b0, cur_req, "unexpected outcome", int'(pass), 0);
      else begin
        bit e;
        e = exp_out_q.pop_front();
        check(pass == e && halt == !e, cur_req, "outcome pass", int'(pass), int'(e));
      end
    end
    done_prev = rst_n && (pass || halt);
  end

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    exp_addr_q.delete();
    exp_out_q.delete();
    mem.delete();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] d, input bit err);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_err = err;
    @(negedge clk);
    rx_valid = 1'b0; rx_err = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // k: first non-FF offset in the top region (-1 = blank part)
  task automatic run_case(input string req, input int k, input logic [15:0] ca,
                          input logic [15:0] pa, input int n, input int bad,
                          input int err, input bit exp_pass);
    int last;
    do_reset();
    cur_req = req;
    if (k >= 0) mem[int'(BASE) + k] = 8'h3C;
    mem[int'(ca)] = 8'(n);
    for (int i = 0; i < n; i++) mem[int'(16'(pa + 16'(i)))] = pw_buf[i];
    for (int i = 0; i <= ((k < 0) ? 31 : k); i++) exp_addr_q.push_back(16'(BASE + 16'(i)));
    if (k >= 0) begin
      exp_addr_q.push_back(ca);
      last = (bad >= 0) ? bad : (err >= 0) ? err : n - 1;
      for (int i = 0; i <= last; i++) exp_addr_q.push_back(16'(pa + 16'(i)));
    end
    exp_out_q.push_back(exp_pass);
    cnt_addr = ca; cmp_addr = pa;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (45) @(negedge clk);
    for (int i = 0; i < ((k < 0) ? 3 : n); i++) begin
      send_byte((i == bad || k < 0) ? ~pw_buf[i] : pw_buf[i], i == err);
      if (i == err) break;
    end
    for (int i = 0; i < 300; i++) begin
      if (pass || halt) break;
      @(negedge clk);
    end
    repeat (5) @(negedge clk);
    check(pass == exp_pass, req, "pass_o held", int'(pass), int'(exp_pass));
    check(halt == !exp_pass, req, "halt_o held", int'(halt), int'(!exp_pass));
    check(exp_addr_q.size() == 0, req, "missing reads", exp_addr_q.size(), 0);
    check(exp_out_q.size() == 0, req, "missing outcome", exp_out_q.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1: outputs quiet in reset
    check(!busy && !pass && !halt && !mem_re, "R1", "outputs in reset",
          {busy, pass, halt, mem_re}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !pass && !halt && !mem_re, "R1", "outputs after reset",
          {busy, pass, halt, mem_re}, 0);

    pw_buf[0] = 8'hA5; pw_buf[1] = 8'h3C; pw_buf[2] = 8'h00; pw_buf[3] = 8'hFF;
    pw_buf[4] = 8'h12; pw_buf[5] = 8'h81; pw_buf[6] = 8'h7E; pw_buf[7] = 8'h5A;

    // R3: blank part, wrong bytes ignored
    run_case("R3", -1, 16'h1000, 16'h2000, 3, -1, -1, 1'b1);
    // R2 R4 R5 R6: programmed at offset 5, correct password
    run_case("R4", 5, 16'h1000, 16'h2000, 3, -1, -1, 1'b1);
    // R10: a second start after pass is ignored (no reads, pass held)
    cur_req = "R10";
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    check(pass && !halt && !busy, "R10", "restart ignored", {pass, halt, busy}, 3'b100);
    // R6: full 8-byte password, last scan offset
    run_case("R6", 31, 16'h0040, 16'h0100, 8, -1, -1, 1'b1);
    // R5: compare address wraps past FFFFH
    run_case("R5", 0, 16'h0010, 16'hFFFF, 2, -1, -1, 1'b1);
    // R7: mismatch on byte 2, later bytes ignored
    run_case("R7", 2, 16'h0300, 16'h0400, 5, 2, -1, 1'b0);
    // R7: mismatch on first byte
    run_case("R7", 10, 16'h0300, 16'h0400, 4, 0, -1, 1'b0);
    // R8: receive error on byte 1
    run_case("R8", 7, 16'h0500, 16'h0600, 4, -1, 1, 1'b0);
    // R9: zero length passes without compare reads
    run_case("R9", 3, 16'h0700, 16'h0800, 0, -1, -1, 1'b1);
    // R11: no reads while idle
    do_reset();
    cur_req = "R11";
    repeat (10) @(negedge clk);
    check(!mem_re && !busy, "R11", "idle reads", int'(mem_re), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule